// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies the single even-parity bit that guards a 32-bit multiplexed address/data word together with its 4-bit command/byte-enable lanes. Every clock it folds the current word into one parity bit and presents it on the following clock, so that the word and its parity bit together always hold an even number of ones. The same registered bit is compared with the parity bit received from the bus one clock after the word.

A mismatch is reported only for words that matter. These are address phases, and data phases that actually completed. The phase-type inputs tell the block which is which. A data-phase mismatch pulls the parity-error output low two clocks after the faulty phase, then drives it high for one clock before releasing it. A mismatch on an address phase, or on a data phase of a special-cycle transaction, goes to the open-drain system-error pull instead. A checking enable gates all reporting. A sticky flag, cleared by a one on the clear input, records that any error was reported.

Top module: `pci_parity_unit`

## Requirements
- R1: In clock n+1, `par_o` equals the XOR of all bits of `ad_i` and `cbe_i` from clock n, so those 36 bits plus `par_o` hold an even count of ones. `par_oe_o` in clock n+1 equals `drive_i` from clock n.
- R2: A word sampled in clock n may be a completed data phase (`data_xfer_i`=1, `addr_phase_i`=0) of a non-special transaction. If checking is enabled for it and `par_i` in clock n+1 differs from its correct parity, then in clock n+2 `perr_n_o` is 0 and `perr_oe_o` is 1.
- R3: When `perr_n_o` has been low and no new data error follows, the next clock has `perr_n_o`=1 with `perr_oe_o`=1. The clock after that has `perr_oe_o`=0, unless a new error arrives.
- R4: Data errors on consecutive clocks hold `perr_n_o` low without any high clock between them.
- R5: A word with neither `addr_phase_i` nor `data_xfer_i` set is never reported, whatever `par_i` carries for it.
- R6: A parity mismatch on an address phase (`addr_phase_i`=1) sets `serr_pull_o`=1 in clock n+2 and leaves `perr_n_o` unaffected.
- R7: A transaction is special when `cbe_i` equals 4'b0001 (raw bus levels) in its address phase. It stays special until the next address phase. Its completed data phases with bad parity go to `serr_pull_o`, not to `perr_n_o`.
- R8: A word sampled while `chk_en_i`=0 is never reported, on either error output.
- R9: `err_flag_o` goes to 1 in the clock in which any error is first shown on `perr_n_o` or `serr_pull_o`, and stays at 1. A 1 on `clr_i` clears it on the next clock, unless an error is reported in the same clock, in which case setting wins.
- R10: While `rst_n` is 0, `par_oe_o`, `perr_oe_o`, `serr_pull_o` and `err_flag_o` are 0, and `perr_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_en_i | input | 1 | Enables reporting for the word on the bus this clock |
| addr_phase_i | input | 1 | The current word is an address phase |
| data_xfer_i | input | 1 | A data phase completes this clock |
| drive_i | input | 1 | This agent drives the address/data lines this clock |
| ad_i | input | 32 | Address/data lines as seen on the bus |
| cbe_i | input | 4 | Command/byte-enable lines as seen on the bus (raw levels) |
| par_i | input | 1 | Received parity bit, one clock behind its word |
| clr_i | input | 1 | Write-one clear of the sticky error flag |
| par_o | output | 1 | Generated parity for the previous clock's word |
| par_oe_o | output | 1 | Output enable for `par_o` |
| perr_n_o | output | 1 | Data parity error, active low |
| perr_oe_o | output | 1 | Output enable for `perr_n_o` |
| serr_pull_o | output | 1 | Pull the open-drain system-error line low |
| err_flag_o | output | 1 | Sticky record of any reported error |

## Verification
Random words drive the parity generator across the whole 36-bit input space, with parity computed arithmetically in the bench. This separates correct lane folding from any dropped or doubled bit. Phase flags, enable, clear and injected parity faults are mixed each clock. The mix separates completed data phases, idle words, address phases and special-cycle data phases, which must each go to a different output or to none. Runs of faults on adjacent clocks tell a stretched low period apart from a glitch, and isolated faults exercise the one-clock high drive before release.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    // One captured bus word, waiting for its parity bit
    typedef struct packed {
        logic par;
        logic addr;
        logic data;
        logic en;
        logic drive;
        logic spec;
    } word_st_t;

    typedef struct packed {
        word_st_t s1;
        logic     cmd_spec;
        logic     serr;
        logic     sticky;
    } core_st_t;

    typedef struct packed {
        logic act;
        logic tail;
    } perr_st_t;

endpackage

// File: rtl/par_tree.sv
module par_tree #(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] be,
    output logic            par
);
    localparam int LANE_W = AD_W / BE_W;

    logic [BE_W-1:0] lane_par;

    // Each byte lane folds with its own enable bit
    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        assign lane_par[i] = (^ad[i*LANE_W +: LANE_W]) ^ be[i];
    end

    assign par = ^lane_par;

endmodule

// File: rtl/perr_drv.sv
module perr_drv
    import pci_par_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_i,
    output logic perr_n_o,
    output logic perr_oe_o
);
    perr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.act  = err_i;
        st_d.tail = st_q.act & ~err_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign perr_n_o  = ~st_q.act;
    assign perr_oe_o = st_q.act | st_q.tail;

    // R3
    perr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe_o && perr_n_o) |-> $past(perr_oe_o && !perr_n_o));

    // R3
    perr_low_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe_o && !perr_n_o) |=> perr_oe_o);

    // R4
    perr_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_n_o && err_i) |=> !perr_n_o);

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
    import pci_par_pkg::*;
#(
    parameter int              AD_W        = 32,
    parameter int              BE_W        = 4,
    parameter logic [BE_W-1:0] SPECIAL_CMD = BE_W'(1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chk_en_i,
    input  logic            addr_phase_i,
    input  logic            data_xfer_i,
    input  logic            drive_i,
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_i,
    input  logic            par_i,
    input  logic            clr_i,
    output logic            par_o,
    output logic            par_oe_o,
    output logic            perr_n_o,
    output logic            perr_oe_o,
    output logic            serr_pull_o,
    output logic            err_flag_o
);
    core_st_t st_d, st_q;
    logic     word_par;
    logic     mism;
    logic     data_err;
    logic     sys_err;

    par_tree #(.AD_W(AD_W), .BE_W(BE_W)) u_tree (
        .ad  (ad_i),
        .be  (cbe_i),
        .par (word_par)
    );

    // Received bit belongs to the word captured last clock
    assign mism     = st_q.s1.par ^ par_i;
    assign data_err = st_q.s1.en & st_q.s1.data & ~st_q.s1.spec & mism;
    assign sys_err  = st_q.s1.en & mism &
                      (st_q.s1.addr | (st_q.s1.data & st_q.s1.spec));

    always_comb begin
        st_d          = st_q;
        st_d.s1.par   = word_par;
        st_d.s1.addr  = addr_phase_i;
        st_d.s1.data  = data_xfer_i & ~addr_phase_i;
        st_d.s1.en    = chk_en_i;
        st_d.s1.drive = drive_i;
        st_d.s1.spec  = st_q.cmd_spec;
        if (addr_phase_i) st_d.cmd_spec = (cbe_i == SPECIAL_CMD);
        st_d.serr     = sys_err;
        st_d.sticky   = (st_q.sticky & ~clr_i) | data_err | sys_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    perr_drv u_perr (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_i     (data_err),
        .perr_n_o  (perr_n_o),
        .perr_oe_o (perr_oe_o)
    );

    assign par_o       = st_q.s1.par;
    assign par_oe_o    = st_q.s1.drive;
    assign serr_pull_o = st_q.serr;
    assign err_flag_o  = st_q.sticky;

    // R1
    par_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe_o |-> (par_o == ^{$past(ad_i), $past(cbe_i)}));

    // R8
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!chk_en_i, 2) |-> (perr_n_o && !serr_pull_o));

    // R5
    idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!addr_phase_i && !data_xfer_i, 2) |-> (perr_n_o && !serr_pull_o));

    // R9
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_pull_o || !perr_n_o) |-> err_flag_o);

    // R6
    addr_no_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr_phase_i, 2) |-> perr_n_o);

endmodule

// File: tb/pci_parity_unit_tb.sv
module pci_parity_unit_tb;
    localparam int CLK_P = 10;
    localparam int NV    = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_en = 1'b0, addr = 1'b0, xfer = 1'b0, drive = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic        par_in = 1'b0, clr = 1'b0;
    logic        par_o, par_oe_o, perr_n_o, perr_oe_o, serr_pull_o, err_flag_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    pci_parity_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .chk_en_i     (chk_en),
        .addr_phase_i (addr),
        .data_xfer_i  (xfer),
        .drive_i      (drive),
        .ad_i         (ad),
        .cbe_i        (cbe),
        .par_i        (par_in),
        .clr_i        (clr),
        .par_o        (par_o),
        .par_oe_o     (par_oe_o),
        .perr_n_o     (perr_n_o),
        .perr_oe_o    (perr_oe_o),
        .serr_pull_o  (serr_pull_o),
        .err_flag_o   (err_flag_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic p_par, p_addr, p_xfer, p_en, p_spec;
        logic m_spec, m_act, m_tail, m_serr, m_sticky;
        logic cur_par, cur_spec, inj, ed, es, was_act;
        logic [31:0] r;
        string tag;
        p_par = 0; p_addr = 0; p_xfer = 0; p_en = 0; p_spec = 0;
        m_spec = 0; m_act = 0; m_tail = 0; m_serr = 0; m_sticky = 0;

        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10 par_oe_o", {31'b0, par_oe_o}, 0);
        chk("R10 perr_oe_o", {31'b0, perr_oe_o}, 0);
        chk("R10 perr_n_o", {31'b0, perr_n_o}, 1);
        chk("R10 serr_pull_o", {31'b0, serr_pull_o}, 0);
        chk("R10 err_flag_o", {31'b0, err_flag_o}, 0);
        rst_n = 1'b1;

        for (int c = 0; c < NV; c++) begin
            r      = $urandom;
            inj    = (r[1:0] == 2'd0);
            par_in = p_par ^ inj;
            ad     = $urandom;
            addr   = (r[4:2] == 3'd0);
            xfer   = !addr && r[5];
            cbe    = (addr && r[6]) ? 4'b0001 : 4'(r[18:15]);
            drive  = r[7];
            chk_en = (r[10:8] != 3'd0);
            clr    = (r[14:11] == 4'd0);
            cur_par  = ^{ad, cbe};
            cur_spec = m_spec;

            @(posedge clk);
            #1;

            ed = p_en && p_xfer && !p_spec && inj;
            es = p_en && inj && (p_addr || (p_xfer && p_spec));
            was_act  = m_act;
            m_tail   = m_act && !ed;
            m_act    = ed;
            m_serr   = es;
            m_sticky = (m_sticky && !clr) || ed || es;
            if (addr) m_spec = (cbe == 4'b0001);

            // R1: lagged even parity and its enable
            chk("R1 par_o", {31'b0, par_o}, {31'b0, cur_par});
            chk("R1 par_oe_o", {31'b0, par_oe_o}, {31'b0, drive});

            if (m_act && was_act)            tag = "R4 perr_n_o";
            else if (m_tail)                 tag = "R3 perr_n_o";
            else if (inj && !p_en)           tag = "R8 perr_n_o";
            else if (inj && p_addr)          tag = "R6 perr_n_o";
            else if (inj && p_xfer && p_spec) tag = "R7 perr_n_o";
            else if (inj && !p_xfer)         tag = "R5 perr_n_o";
            else                             tag = "R2 perr_n_o";
            chk(tag, {31'b0, perr_n_o}, {31'b0, !m_act});
            chk({tag, " oe"}, {31'b0, perr_oe_o}, {31'b0, (m_act || m_tail)});

            if (inj && p_xfer && p_spec)     tag = "R7 serr_pull_o";
            else if (inj && !p_en)           tag = "R8 serr_pull_o";
            else                             tag = "R6 serr_pull_o";
            chk(tag, {31'b0, serr_pull_o}, {31'b0, m_serr});
            chk("R9 err_flag_o", {31'b0, err_flag_o}, {31'b0, m_sticky});

            p_par  = cur_par;
            p_addr = addr;
            p_xfer = xfer;
            p_en   = chk_en;
            p_spec = cur_spec;
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule